// File: doc/BRIEF.md
# SECDED Protected Memory Controller

This block sits between a simple request/response bus and a word-addressed storage array. Every 64-bit data word is stored together with 8 check bits. The check bits are produced by an odd-column-weight single-error-correcting, double-error-detecting code. On each read the stored word is checked. A single flipped bit is repaired before the data goes back to the requester. A two-bit fault is reported with a bus error response instead.

A static enable input switches checking on and off. With checking off, a write replaces only the data half of the stored word and keeps the old check bits. Software uses this to plant a known fault: write a word with checking on, write an altered copy with checking off, then read it back with checking on. Every checked read that finds a fault does four things:
- it bumps a saturating counter for its class (single or double);
- it sets a sticky flag for that class;
- it pulses a one-cycle interrupt for that class;
- it records the word address and the raw stored data bits.

A clear input wipes all of this recorded state.

Top module: `secded_mem_edac`

## Requirements
- R1: The check bits are computed from the 64 data bits. Data bit i has an 8-bit column value. The first 56 columns are the 8-bit values of weight three in ascending numeric order. The last 8 columns are the 8-bit values of weight five in ascending numeric order. Check bit j is the XOR of the data bits whose column has bit j set, so data 0 yields check 0.
- R2: A checked read of a word whose syndrome is zero returns the stored data with resp_err low. It leaves counters, flags and interrupts unchanged. The syndrome is the stored check bits XOR the check bits recomputed from the stored data.
- R3: A checked read whose syndrome has odd weight and equals the column of data bit i returns the data with bit i inverted. That read pulses irq_single for one cycle, sets err_single_flag and increments sb_count.
- R4: A checked read whose syndrome has exactly one bit set is a check-bit fault. It returns the stored data unchanged and is counted exactly like R3.
- R5: Any other nonzero syndrome is an uncorrectable fault. That is an even-weight syndrome, or an odd-weight syndrome that matches no column. Such a read returns the raw stored data with resp_err high, pulses irq_double, sets err_double_flag and increments db_count.
- R6: Every read counted under R3, R4 or R5 loads last_err_addr with its word address and last_err_data with the raw stored data bits before correction.
- R7: A write issued while edac_on is low replaces the data bits and keeps the previous check bits. A read issued while edac_on is low returns the raw data with resp_err low and causes no count, flag, capture or interrupt.
- R8: Reset clears both counters, both flags, last_err_addr and last_err_data. The clr_stats input clears the same state. A clr_stats asserted in the cycle an error would be recorded wins, and the state ends up cleared.
- R9: A request sampled at clock edge k yields resp_valid high for exactly the one cycle after edge k+1. A write response carries resp_rdata zero and resp_err low. irq_single and irq_double are high only in a response cycle.
- R10: sb_count and db_count stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edac_on | input | 1 | Checking enable, sampled with each request |
| clr_stats | input | 1 | Clears counters, flags and capture registers |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response strobe |
| resp_rdata | output | 64 | Read data (corrected when possible) |
| resp_err | output | 1 | Bus error: uncorrectable fault on read |
| irq_single | output | 1 | One-cycle pulse on a corrected fault |
| irq_double | output | 1 | One-cycle pulse on an uncorrectable fault |
| err_single_flag | output | 1 | Sticky single-fault status |
| err_double_flag | output | 1 | Sticky double-fault status |
| sb_count | output | CNT_W | Single-fault counter, saturating |
| db_count | output | CNT_W | Double-fault counter, saturating |
| last_err_addr | output | ADDR_W | Address of the most recent faulty read |
| last_err_data | output | 64 | Raw data bits of the most recent faulty read |

## Verification
Words are first written with checking on, then rewritten with zero, one or two random bits flipped while checking is off, and read back with checking on. These three patterns separate clean reads, in-place correction and bus-error reporting. A directed three-bit flip of data bits 0, 1 and 2 gives a syndrome of exactly one bit, which takes the check-bit-fault path and returns the data unchanged. Reads with checking off show raw pass-through with no side effects. Runs of faults with a narrow counter reach saturation. A clear that lands in the same cycle as an error proves that clearing has priority.

// File: rtl/edac_pkg.sv
package edac_pkg;

    localparam int DW     = 64;
    localparam int CW     = 8;
    localparam int CODE_W = DW + CW;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [CW-1:0] chk;
    } code_word_t;

    typedef enum logic [1:0] {
        FAULT_NONE   = 2'd0,
        FAULT_SINGLE = 2'd1,
        FAULT_DOUBLE = 2'd2
    } fault_kind_t;

    typedef struct packed {
        logic [DW-1:0] data;
        fault_kind_t   kind;
    } dec_result_t;

    // Column of data bit idx: weight-3 values ascending, then weight-5 values ascending.
    function automatic logic [CW-1:0] col_of(input int idx);
        int             n;
        logic [CW-1:0]  r;
        logic [CW-1:0]  vv;
        n = 0;
        r = '0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 0; v < (1 << CW); v++) begin
                vv = v[CW-1:0];
                if ($countones(vv) == w) begin
                    if (n == idx) r = vv;
                    n++;
                end
            end
        end
        return r;
    endfunction

    // Data bits that feed check bit j.
    function automatic logic [DW-1:0] row_mask(input int j);
        logic [DW-1:0] m;
        logic [CW-1:0] c;
        for (int i = 0; i < DW; i++) begin
            c    = col_of(i);
            m[i] = c[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/edac_encoder.sv
module edac_encoder
    import edac_pkg::*;
(
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] chk_o
);

    for (genvar j = 0; j < CW; j++) begin : g_row
        localparam logic [DW-1:0] MASK = row_mask(j);
        assign chk_o[j] = ^(data_i & MASK);
    end

endmodule

// File: rtl/edac_decoder.sv
module edac_decoder
    import edac_pkg::*;
(
    input  code_word_t  word_i,
    output dec_result_t res_o
);

    logic [CW-1:0] recomputed;
    logic [CW-1:0] syn;
    logic [DW-1:0] hit;

    edac_encoder u_enc (
        .data_i (word_i.data),
        .chk_o  (recomputed)
    );

    assign syn = word_i.chk ^ recomputed;

    for (genvar i = 0; i < DW; i++) begin : g_col
        localparam logic [CW-1:0] COL = col_of(i);
        assign hit[i] = (syn == COL);
    end

    always_comb begin
        res_o.data = word_i.data ^ hit;
        if (syn == '0)
            res_o.kind = FAULT_NONE;
        else if ((^syn) && ((|hit) || $onehot(syn)))
            res_o.kind = FAULT_SINGLE;
        else
            res_o.kind = FAULT_DOUBLE;
    end

endmodule

// File: rtl/edac_store.sv
module edac_store
    import edac_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              chk_wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [CW-1:0]     wchk,
    output code_word_t        rword_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] dmem [DEPTH];
    logic [CW-1:0] cmem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) dmem[addr] <= wdata;
        if (wr_en && chk_wr_en) cmem[addr] <= wchk;
        if (rd_en) begin
            rword_o.data <= dmem[addr];
            rword_o.chk  <= cmem[addr];
        end
    end

endmodule

// File: rtl/secded_mem_edac.sv
module secded_mem_edac
    import edac_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edac_on,
    input  logic              clr_stats,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              resp_valid,
    output logic [DW-1:0]     resp_rdata,
    output logic              resp_err,
    output logic              irq_single,
    output logic              irq_double,
    output logic              err_single_flag,
    output logic              err_double_flag,
    output logic [CNT_W-1:0]  sb_count,
    output logic [CNT_W-1:0]  db_count,
    output logic [ADDR_W-1:0] last_err_addr,
    output logic [DW-1:0]     last_err_data
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CW-1:0]     wr_chk;
    code_word_t        raw_word;
    dec_result_t       dec;
    logic              s1_valid, s1_write, s1_chk;
    logic [ADDR_W-1:0] s1_addr;
    logic              do_check, hit_single, hit_double, is_read;

    edac_encoder u_wenc (
        .data_i (req_wdata),
        .chk_o  (wr_chk)
    );

    edac_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .wr_en     (req_valid && req_write),
        .chk_wr_en (edac_on),
        .rd_en     (req_valid && !req_write),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .wchk      (wr_chk),
        .rword_o   (raw_word)
    );

    edac_decoder u_dec (
        .word_i (raw_word),
        .res_o  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_write <= 1'b0;
            s1_chk   <= 1'b0;
            s1_addr  <= '0;
        end else begin
            s1_valid <= req_valid;
            s1_write <= req_write;
            s1_chk   <= edac_on;
            s1_addr  <= req_addr;
        end
    end

    assign is_read    = s1_valid && !s1_write;
    assign do_check   = is_read && s1_chk;
    assign hit_single = do_check && (dec.kind == FAULT_SINGLE);
    assign hit_double = do_check && (dec.kind == FAULT_DOUBLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid      <= 1'b0;
            resp_rdata      <= '0;
            resp_err        <= 1'b0;
            irq_single      <= 1'b0;
            irq_double      <= 1'b0;
            err_single_flag <= 1'b0;
            err_double_flag <= 1'b0;
            sb_count        <= '0;
            db_count        <= '0;
            last_err_addr   <= '0;
            last_err_data   <= '0;
        end else begin
            resp_valid <= s1_valid;
            resp_rdata <= !is_read ? '0 : (s1_chk ? dec.data : raw_word.data);
            resp_err   <= hit_double;
            irq_single <= hit_single;
            irq_double <= hit_double;
            if (clr_stats) begin
                err_single_flag <= 1'b0;
                err_double_flag <= 1'b0;
                sb_count        <= '0;
                db_count        <= '0;
                last_err_addr   <= '0;
                last_err_data   <= '0;
            end else if (hit_single || hit_double) begin
                last_err_addr <= s1_addr;
                last_err_data <= raw_word.data;
                if (hit_single) begin
                    err_single_flag <= 1'b1;
                    if (sb_count != CNT_MAX) sb_count <= sb_count + 1'b1;
                end else begin
                    err_double_flag <= 1'b1;
                    if (db_count != CNT_MAX) db_count <= db_count + 1'b1;
                end
            end
        end
    end

    // R9: a request is answered two edges later
    a_r9_resp_timing: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ##1 resp_valid);

    // R5: bus error only on a response, together with its interrupt
    a_r5_err_with_irq: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_valid && irq_double));

    // R9: interrupts only in response cycles, never both classes
    a_r9_irq_in_resp: assert property (@(posedge clk) disable iff (rst)
        (irq_single || irq_double) |-> (resp_valid && !(irq_single && irq_double)));

    // R10: counter moves by at most one, never wraps
    a_r10_sb_step: assert property (@(posedge clk) disable iff (rst)
        !clr_stats |=> (sb_count == $past(sb_count)) ||
                       (sb_count == $past(sb_count) + 1'b1));

    a_r10_db_step: assert property (@(posedge clk) disable iff (rst)
        !clr_stats |=> (db_count == $past(db_count)) ||
                       (db_count == $past(db_count) + 1'b1));

    // R8: clear empties the counters
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clr_stats |=> (sb_count == '0 && db_count == '0 &&
                       !err_single_flag && !err_double_flag));

    // R7: unchecked reads raise nothing
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_chk) |=> (!irq_single && !irq_double && !resp_err));

endmodule

// File: tb/secded_mem_edac_tb_top.sv
module secded_mem_edac_tb_top;

    localparam int AW = 6;
    localparam int CN = 4;
    localparam int NW = 1 << AW;
    localparam int CMAX = (1 << CN) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          edac_on, clr_stats, req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [63:0]   req_wdata;
    logic          resp_valid, resp_err, irq_single, irq_double;
    logic          err_single_flag, err_double_flag;
    logic [63:0]   resp_rdata, last_err_data;
    logic [CN-1:0] sb_count, db_count;
    logic [AW-1:0] last_err_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    secded_mem_edac #(.ADDR_W(AW), .CNT_W(CN)) dut_i (
        .clk(clk), .rst(rst), .edac_on(edac_on), .clr_stats(clr_stats),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .resp_err(resp_err), .irq_single(irq_single), .irq_double(irq_double),
        .err_single_flag(err_single_flag), .err_double_flag(err_double_flag),
        .sb_count(sb_count), .db_count(db_count),
        .last_err_addr(last_err_addr), .last_err_data(last_err_data)
    );

    // reference model
    logic [7:0]  cols [64];
    logic [63:0] bdata [NW];
    logic [7:0]  bchk [NW];
    int          m_sb, m_db;
    bit          m_fs, m_fd;
    logic [63:0] m_laddr, m_ldata;

    function automatic int popc(input logic [7:0] v);
        int c = 0;
        for (int b = 0; b < 8; b++) c += v[b];
        return c;
    endfunction

    function automatic logic [7:0] benc(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
        return c;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check_stats(input string tag);
        chk({tag, " R3 sb_count"}, 64'(sb_count), 64'(m_sb));
        chk({tag, " R5 db_count"}, 64'(db_count), 64'(m_db));
        chk({tag, " R3 single flag"}, 64'(err_single_flag), 64'(m_fs));
        chk({tag, " R5 double flag"}, 64'(err_double_flag), 64'(m_fd));
        chk({tag, " R6 last addr"}, 64'(last_err_addr), m_laddr);
        chk({tag, " R6 last data"}, last_err_data, m_ldata);
    endtask

    task automatic do_op(input string tag, input bit wr, input bit en,
                         input int unsigned a, input logic [63:0] d, input bit clr);
        logic [63:0] exp_d;
        logic [7:0]  syn;
        int          kind;
        exp_d = 64'd0;
        kind  = 0;
        @(negedge clk);
        edac_on = en; req_valid = 1'b1; req_write = wr;
        req_addr = a[AW-1:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; clr_stats = clr;
        @(negedge clk);
        clr_stats = 1'b0;
        if (wr) begin
            bdata[a] = d;
            if (en) bchk[a] = benc(d);
        end else if (!en) begin
            exp_d = bdata[a];
        end else begin
            exp_d = bdata[a];
            syn = bchk[a] ^ benc(bdata[a]);
            if (syn != 8'd0) begin
                kind = 2;
                if (popc(syn) % 2 == 1) begin
                    if (popc(syn) == 1) kind = 1;
                    for (int i = 0; i < 64; i++)
                        if (cols[i] == syn) begin exp_d[i] = ~exp_d[i]; kind = 1; end
                end
            end
            if (kind != 0) begin
                m_laddr = 64'(a); m_ldata = bdata[a];
                if (kind == 1) begin m_fs = 1; if (m_sb < CMAX) m_sb++; end
                else begin m_fd = 1; if (m_db < CMAX) m_db++; end
            end
        end
        if (clr) begin
            m_sb = 0; m_db = 0; m_fs = 0; m_fd = 0; m_laddr = 0; m_ldata = 0;
        end
        chk({tag, " R9 resp_valid"}, 64'(resp_valid), 64'd1);
        chk({tag, " R2 rdata"}, resp_rdata, exp_d);
        chk({tag, " R5 resp_err"}, 64'(resp_err), 64'(kind == 2));
        chk({tag, " R3 irq_single"}, 64'(irq_single), 64'(kind == 1));
        chk({tag, " R5 irq_double"}, 64'(irq_double), 64'(kind == 2));
        check_stats(tag);
    endtask

    task automatic inject(input string tag, input int unsigned a, input logic [63:0] d,
                          input logic [63:0] flip, input bit clr);
        do_op({tag, " wr"}, 1'b1, 1'b1, a, d, 1'b0);
        do_op({tag, " R7 wr-off"}, 1'b1, 1'b0, a, d ^ flip, 1'b0);
        do_op({tag, " rd"}, 1'b0, 1'b1, a, 64'd0, clr);
    endtask

    function automatic logic [63:0] rand_flip(input int n);
        logic [63:0] f = '0;
        int b;
        while ($countones(f) < n) begin
            b = int'($urandom_range(63, 0));
            f[b] = 1'b1;
        end
        return f;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n = 0;
        for (int w = 3; w <= 5; w += 2)
            for (int v = 0; v < 256; v++)
                if (popc(v[7:0]) == w && n < 64) begin cols[n] = v[7:0]; n++; end
        m_sb = 0; m_db = 0; m_fs = 0; m_fd = 0; m_laddr = 0; m_ldata = 0;
        void'($urandom(32'd20240));
        rst = 1'b1; edac_on = 1'b1; clr_stats = 1'b0; req_valid = 1'b0;
        req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset resp_valid", 64'(resp_valid), 64'd0);
        check_stats("R8 reset");

        // R1 fill memory with checking on
        for (int a = 0; a < NW; a++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            do_op("R1 fill", 1'b1, 1'b1, a, d, 1'b0);
        end
        // R1 zero word encodes to zero check, reads clean
        do_op("R1 zero wr", 1'b1, 1'b1, 5, 64'd0, 1'b0);
        do_op("R1 zero rd", 1'b0, 1'b1, 5, 64'd0, 1'b0);
        // R2 clean reads
        for (int i = 0; i < 8; i++) do_op("R2 clean", 1'b0, 1'b1, i * 7, 64'd0, 1'b0);

        // R3 directed: bit 0 and bit 63
        inject("R3 bit0", 3, 64'hDEAD_BEEF_0123_4567, 64'd1, 1'b0);
        inject("R3 bit63", 4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0);
        // R4 directed: flips of data bits 0,1,2 give a one-hot syndrome
        inject("R4 chkpath", 9, 64'h0F0F_0F0F_0F0F_0F0F, 64'h7, 1'b0);
        // R5 directed double
        inject("R5 double", 10, 64'h1234_5678_9ABC_DEF0, 64'h0000_0100_0000_0001, 1'b0);
        // R7 read with checking off: raw, no side effects
        do_op("R7 wr-off", 1'b1, 1'b0, 11, 64'hAAAA_5555_AAAA_5555, 1'b0);
        do_op("R7 rd-off", 1'b0, 1'b0, 11, 64'd0, 1'b0);

        // R8 clear colliding with an error
        inject("R8 clr-collide", 12, 64'h0BAD_F00D_0BAD_F00D, 64'h20, 1'b1);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int unsigned a;
            int          nf;
            a  = $urandom_range(NW - 1, 0);
            nf = int'($urandom_range(2, 0));
            if ($urandom_range(9, 0) == 0)
                inject("R7 rand-off", a, {$urandom, $urandom}, rand_flip(nf), 1'b0);
            else
                inject("R3 rand", a, {$urandom, $urandom}, rand_flip(nf), 1'b0);
            if ($urandom_range(15, 0) == 0)
                do_op("R7 rand rd-off", 1'b0, 1'b0, a, 64'd0, 1'b0);
        end

        // R10 saturation of both counters
        do_op("R8 clr", 1'b0, 1'b1, 0, 64'd0, 1'b1);
        for (int k = 0; k < 20; k++) inject("R10 sat-single", 20, 64'h55, 64'h100, 1'b0);
        for (int k = 0; k < 20; k++) inject("R10 sat-double", 21, 64'h66, 64'h3, 1'b0);
        chk("R10 sb saturated", 64'(sb_count), 64'(CMAX));
        chk("R10 db saturated", 64'(db_count), 64'(CMAX));

        summary();
        $finish;
    end

endmodule